// File: doc/BRIEF.md
# Home-Node Sharer Directory Controller

This block keeps the coherence directory for a set of memory blocks at their home node. For each block it stores a stable state (unowned, shared or exclusive), an owner node id and a sharer field of fixed width. Requests arrive one at a time with an operation, a requesting node id and a block index. Because every request passes through the one port, writes to a block are serialized here. The block returns a forward target for reads that hit an exclusive copy. For each write it produces an invalidation list, one destination node per cycle, and then an acknowledge count.

The sharer field width `VEC_W` does not depend on the node count `NODES`. At elaboration the ratio of the two selects the encoding. When `NODES <= VEC_W`, the field is a full bit vector with one bit per node. Otherwise it is a coarse vector, with one bit per group of `GROUP = ceil(NODES/VEC_W)` consecutive nodes. Presence is kept per node, and a node contains two processors. An invalidation addressed to a node therefore covers both processors, and no processor index appears anywhere in the interface.

Top module: `dir_sharer_ctrl`

## Requirements
- R1: After reset `req_ready_o` is 1 and `inv_valid_o`, `ack_valid_o` and `fwd_valid_o` are 0. Every block is unowned, so a first write to any block reports an acknowledge count of 0.
- R2: Op encodings on `req_op_i` are 0 = read, 1 = write, 2 = evict, and 3 = no change. A read to an unowned or shared block records the requester as a sharer.
- R3: A write accepted at a clock edge issues one invalidation per cycle, starting in the next cycle. The invalidations go to every node recorded for the block except the requester, each exactly once, in ascending node id order.
- R4: `ack_valid_o` is high for exactly one cycle. That cycle follows the last invalidation, or follows the accepting edge if there were no invalidations. `ack_cnt_o` then equals the number of invalidations issued.
- R5: `req_ready_o` is 0 from the cycle after a write is accepted up to and including its `ack_valid_o` cycle. A request is accepted only on an edge where `req_valid_i` and `req_ready_o` are both 1.
- R6: After a write, the block is exclusive and owned by the requester.
- R7: A read to an exclusive block by a node other than the owner raises `fwd_valid_o` for one cycle after the accepting edge, with `fwd_node_o` set to the owner. The block becomes shared with both the owner and the reader recorded.
- R8: A read by the owner of an exclusive block produces no forward and leaves the block exclusive.
- R9: In full mode (`NODES <= VEC_W`), bit i of the sharer field stands for node i. An evict from a shared block clears that node's bit, and the block becomes unowned when no bit is left. An evict by the owner of an exclusive block makes it unowned.
- R10: In coarse mode, bit `node / GROUP` stands for the group of nodes. A write invalidates every node of each recorded group except the requester. An evict from a shared block leaves the sharer field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 evict |
| req_node_i | input | NODE_W | Requesting node id |
| req_blk_i | input | BLK_W | Block index |
| inv_valid_o | output | 1 | Invalidation destination valid |
| inv_node_o | output | NODE_W | Node to invalidate (both processors) |
| ack_valid_o | output | 1 | Write finished, count valid |
| ack_cnt_o | output | CNT_W | Number of invalidations issued |
| fwd_valid_o | output | 1 | Read forwarded to owner |
| fwd_node_o | output | NODE_W | Owner node that supplies the data |

## Verification
A corrupted directory entry stays invisible until the next request touches that block. It then shows up as a missing or extra forward in the cycle after a read is accepted, or as a wrong invalidation list and acknowledge count on the next write. The bench keeps a per-block reference model for a full-mode and a coarse-mode instance. It compares the complete invalidation set, its order and the count on every write, so a bad bit is reported at the first write that follows it. A stuck or skipped sequencer step shows within the same write as a duplicate, an out-of-order destination or a wrong count.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    ST_UNOWNED = 2'd0,
    ST_SHARED  = 2'd1,
    ST_EXCL    = 2'd2
  } dir_st_e;
endpackage

// File: rtl/dir_node_map.sv
module dir_node_map #(
  parameter int NODES  = 32,
  parameter int VEC_W  = 16,
  parameter int NODE_W = 5,
  parameter int GROUP  = 2
) (
  input  logic [NODE_W-1:0] node_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [VEC_W-1:0]  node_bit_o,
  output logic [NODES-1:0]  node_mask_o
);
  if (GROUP == 1) begin : g_full
    always_comb node_bit_o = VEC_W'(1) << node_i;
    for (genvar n = 0; n < NODES; n++) begin : g_bit
      assign node_mask_o[n] = vec_i[n];
    end
  end else begin : g_coarse
    always_comb node_bit_o = VEC_W'(1) << (node_i / NODE_W'(GROUP));
    // each node inherits the presence bit of its group
    for (genvar n = 0; n < NODES; n++) begin : g_bit
      assign node_mask_o[n] = vec_i[n / GROUP];
    end
  end
endmodule

// File: rtl/dir_entry_next.sv
module dir_entry_next
  import dir_pkg::*;
#(
  parameter int NODES  = 32,
  parameter int VEC_W  = 16,
  parameter int NODE_W = 5,
  parameter bit COARSE = 1'b1
) (
  input  dir_op_e           op_i,
  input  logic [NODE_W-1:0] node_i,
  input  dir_st_e           st_i,
  input  logic [NODE_W-1:0] own_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [VEC_W-1:0]  node_bit_i,
  input  logic [NODES-1:0]  node_mask_i,
  output dir_st_e           st_o,
  output logic [NODE_W-1:0] own_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              fwd_o,
  output logic [NODES-1:0]  inv_mask_o
);
  logic [NODES-1:0] req_oh, own_oh;
  logic [VEC_W-1:0] vec_clr;

  always_comb begin
    req_oh     = NODES'(1) << node_i;
    own_oh     = NODES'(1) << own_i;
    vec_clr    = vec_i & ~node_bit_i;
    st_o       = st_i;
    own_o      = own_i;
    vec_o      = vec_i;
    fwd_o      = 1'b0;
    inv_mask_o = '0;
    unique case (op_i)
      OP_READ: begin
        if (st_i == ST_EXCL) begin
          if (own_i != node_i) begin
            fwd_o = 1'b1;
            st_o  = ST_SHARED;
            vec_o = vec_i | node_bit_i;  // vec_i already holds the owner
          end
        end else begin
          st_o  = ST_SHARED;
          vec_o = (st_i == ST_SHARED) ? (vec_i | node_bit_i) : node_bit_i;
        end
      end
      OP_WRITE: begin
        if (st_i == ST_SHARED)   inv_mask_o = node_mask_i & ~req_oh;
        else if (st_i == ST_EXCL) inv_mask_o = own_oh & ~req_oh;
        st_o  = ST_EXCL;
        own_o = node_i;
        vec_o = node_bit_i;
      end
      OP_EVICT: begin
        if (st_i == ST_EXCL && own_i == node_i) begin
          st_o  = ST_UNOWNED;
          vec_o = '0;
        end else if (st_i == ST_SHARED && !COARSE) begin
          vec_o = vec_clr;
          if (vec_clr == '0) st_o = ST_UNOWNED;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_inv_seq.sv
module dir_inv_seq #(
  parameter int NODES  = 32,
  parameter int NODE_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [NODES-1:0]  mask_i,
  output logic              busy_o,
  output logic              inv_valid_o,
  output logic [NODE_W-1:0] inv_node_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [NODES-1:0] pend_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NODES - 1; i >= 0; i--) if (pend_q[i]) pick = NODE_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      pend_q <= mask_i;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (|pend_q) begin
        pend_q[pick] <= 1'b0;
        cnt_q        <= cnt_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign inv_valid_o = busy_q & (|pend_q);
  assign inv_node_o  = pick;
  assign done_o      = busy_q & ~(|pend_q);
  assign cnt_o       = cnt_q;

  p_drain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !load_i |=> !pend_q[$past(inv_node_o)]);
  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !load_i |=> cnt_o == $past(cnt_o) + 1'b1);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> !done_o);
endmodule

// File: rtl/dir_sharer_ctrl.sv
module dir_sharer_ctrl
  import dir_pkg::*;
#(
  parameter int NODES = 32,
  parameter int VEC_W = 16,
  parameter int BLKS  = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BLK_W  = (BLKS > 1) ? $clog2(BLKS) : 1,
  localparam int CNT_W  = $clog2(NODES + 1),
  localparam int GROUP  = (NODES + VEC_W - 1) / VEC_W,
  localparam bit COARSE = (NODES > VEC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              inv_valid_o,
  output logic [NODE_W-1:0] inv_node_o,
  output logic              ack_valid_o,
  output logic [CNT_W-1:0]  ack_cnt_o,
  output logic              fwd_valid_o,
  output logic [NODE_W-1:0] fwd_node_o
);
  dir_st_e           st_q  [BLKS];
  logic [NODE_W-1:0] own_q [BLKS];
  logic [VEC_W-1:0]  vec_q [BLKS];

  dir_st_e           nxt_st;
  logic [NODE_W-1:0] nxt_own;
  logic [VEC_W-1:0]  nxt_vec, node_bit;
  logic [NODES-1:0]  node_mask, inv_mask;
  logic              fwd, busy, accept;
  logic [NODE_W-1:0] req_node_q;
  dir_op_e           op;

  assign op          = dir_op_e'(req_op_i);
  assign req_ready_o = ~busy;
  assign accept      = req_valid_i & ~busy;

  dir_node_map #(.NODES(NODES), .VEC_W(VEC_W), .NODE_W(NODE_W), .GROUP(GROUP)) u_map (
    .node_i     (req_node_i),
    .vec_i      (vec_q[req_blk_i]),
    .node_bit_o (node_bit),
    .node_mask_o(node_mask)
  );

  dir_entry_next #(.NODES(NODES), .VEC_W(VEC_W), .NODE_W(NODE_W), .COARSE(COARSE)) u_next (
    .op_i       (op),
    .node_i     (req_node_i),
    .st_i       (st_q[req_blk_i]),
    .own_i      (own_q[req_blk_i]),
    .vec_i      (vec_q[req_blk_i]),
    .node_bit_i (node_bit),
    .node_mask_i(node_mask),
    .st_o       (nxt_st),
    .own_o      (nxt_own),
    .vec_o      (nxt_vec),
    .fwd_o      (fwd),
    .inv_mask_o (inv_mask)
  );

  dir_inv_seq #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && op == OP_WRITE),
    .mask_i     (inv_mask),
    .busy_o     (busy),
    .inv_valid_o(inv_valid_o),
    .inv_node_o (inv_node_o),
    .done_o     (ack_valid_o),
    .cnt_o      (ack_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLKS; b++) begin
        st_q[b]  <= ST_UNOWNED;
        own_q[b] <= '0;
        vec_q[b] <= '0;
      end
      fwd_valid_o <= 1'b0;
      fwd_node_o  <= '0;
      req_node_q  <= '0;
    end else begin
      fwd_valid_o <= accept & fwd;
      if (accept) begin
        st_q[req_blk_i]  <= nxt_st;
        own_q[req_blk_i] <= nxt_own;
        vec_q[req_blk_i] <= nxt_vec;
        fwd_node_o       <= own_q[req_blk_i];
        req_node_q       <= req_node_i;
      end
    end
  end

  p_no_self_inv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> inv_node_o != req_node_q);
  p_busy_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_o || ack_valid_o) |-> !req_ready_o);
  p_fwd_other_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> fwd_node_o != req_node_q);
  p_fwd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> !inv_valid_o && !ack_valid_o);
endmodule

// File: tb/test_dir_sharer_ctrl.sv
`timescale 1ns/1ps
module test_dir_sharer_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       vld [2];
  logic [1:0] op  [2];
  logic [5:0] nd  [2];
  logic [1:0] blk [2];
  logic       rdy [2], iv [2], dv [2], fv [2];
  logic [5:0] inn [2], fn [2];
  logic [6:0] cnt [2];

  logic [3:0] inn0, fn0;
  logic [4:0] cnt0;
  logic [5:0] inn1, fn1;
  logic [6:0] cnt1;

  // full mode: 16 nodes, 16-bit field
  dir_sharer_ctrl #(.NODES(16), .VEC_W(16), .BLKS(4)) i_dir_sharer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld[0]), .req_ready_o(rdy[0]),
    .req_op_i(op[0]), .req_node_i(nd[0][3:0]), .req_blk_i(blk[0]),
    .inv_valid_o(iv[0]), .inv_node_o(inn0), .ack_valid_o(dv[0]), .ack_cnt_o(cnt0),
    .fwd_valid_o(fv[0]), .fwd_node_o(fn0));
  // coarse mode: 64 nodes, 16-bit field, groups of 4
  dir_sharer_ctrl #(.NODES(64), .VEC_W(16), .BLKS(4)) i_dir_sharer_ctrl_c (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld[1]), .req_ready_o(rdy[1]),
    .req_op_i(op[1]), .req_node_i(nd[1]), .req_blk_i(blk[1]),
    .inv_valid_o(iv[1]), .inv_node_o(inn1), .ack_valid_o(dv[1]), .ack_cnt_o(cnt1),
    .fwd_valid_o(fv[1]), .fwd_node_o(fn1));

  assign inn[0] = {2'b0, inn0};
  assign fn[0]  = {2'b0, fn0};
  assign cnt[0] = {2'b0, cnt0};
  assign inn[1] = inn1;
  assign fn[1]  = fn1;
  assign cnt[1] = cnt1;

  int nchk = 0, nerr = 0;
  int          mst  [2][4];
  int          mown [2][4];
  logic [15:0] mvec [2][4];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int grp(input int m); return (m == 0) ? 1 : 4; endfunction
  function automatic int nn(input int m);  return (m == 0) ? 16 : 64; endfunction

  function automatic logic [63:0] exp_inv(input int m, input int b, input int node);
    logic [63:0] r = '0;
    if (mst[m][b] == 1)
      for (int n = 0; n < nn(m); n++) if (mvec[m][b][n / grp(m)]) r[n] = 1'b1;
    if (mst[m][b] == 2) r[mown[m][b]] = 1'b1;
    r[node] = 1'b0;
    return r;
  endfunction

  task automatic model_upd(input int m, input int o, input int node, input int b);
    int bi = node / grp(m);
    case (o)
      0: if (mst[m][b] == 2) begin
           if (mown[m][b] != node) begin mst[m][b] = 1; mvec[m][b][bi] = 1'b1; end
         end else begin
           if (mst[m][b] == 0) mvec[m][b] = '0;
           mst[m][b] = 1; mvec[m][b][bi] = 1'b1;
         end
      1: begin mst[m][b] = 2; mown[m][b] = node; mvec[m][b] = '0; mvec[m][b][bi] = 1'b1; end
      2: if (mst[m][b] == 2 && mown[m][b] == node) begin mst[m][b] = 0; mvec[m][b] = '0; end
         else if (mst[m][b] == 1 && m == 0) begin
           mvec[m][b][bi] = 1'b0;
           if (mvec[m][b] == '0) mst[m][b] = 0;
         end
      default: ;
    endcase
  endtask

  // called at a negedge with the instance idle
  task automatic do_req(input int m, input int o, input int node, input int b);
    logic [63:0] expm, got;
    int last;
    bit expf, done;
    int expn;
    expm = exp_inv(m, b, node);
    expf = (o == 0 && mst[m][b] == 2 && mown[m][b] != node);
    expn = mown[m][b];
    chk(rdy[m] == 1'b1, "R5 ready when idle", rdy[m], 1);
    vld[m] = 1'b1; op[m] = 2'(o); nd[m] = 6'(node); blk[m] = 2'(b);
    @(negedge clk);
    vld[m] = 1'b0;
    if (o == 1) begin
      got = '0; last = -1; done = 0;
      for (int c = 0; c < 100 && !done; c++) begin
        if (dv[m]) begin
          done = 1;
          chk(rdy[m] == 1'b0, "R5 ready low at ack", rdy[m], 0);
          chk(int'(cnt[m]) == $countones(expm), "R4 ack count", cnt[m], $countones(expm));
        end else begin
          chk(iv[m] == 1'b1, "R3 back-to-back invalidation", iv[m], 1);
          chk(rdy[m] == 1'b0, "R5 ready low while invalidating", rdy[m], 0);
          chk(int'(inn[m]) > last, "R3 ascending order", inn[m], last + 1);
          last = int'(inn[m]);
          got[inn[m]] = 1'b1;
          @(negedge clk);
        end
      end
      chk(done, "R4 ack seen", done, 1);
      chk(got == expm, "R3 invalidation set", got, expm);
      @(negedge clk);
      chk(dv[m] == 1'b0 && rdy[m] == 1'b1, "R4 single ack pulse", dv[m], 0);
    end else begin
      chk(fv[m] == expf, "R7 forward valid", fv[m], expf);
      if (expf) chk(int'(fn[m]) == expn, "R7 forward to owner", fn[m], expn);
      chk(iv[m] == 1'b0 && dv[m] == 1'b0, "R2 no invalidation on read or evict", iv[m], 0);
    end
    model_upd(m, o, node, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_c0de));
    for (int m = 0; m < 2; m++) begin
      vld[m] = 0; op[m] = 0; nd[m] = 0; blk[m] = 0;
      for (int b = 0; b < 4; b++) begin mst[m][b] = 0; mown[m][b] = 0; mvec[m][b] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // R1 reset outputs
      chk(rdy[m] == 1 && iv[m] == 0 && dv[m] == 0 && fv[m] == 0, "R1 reset outputs",
          {rdy[m], iv[m], dv[m], fv[m]}, 4'b1000);
    end
    // R1 first write sees no sharers; R6 owner recorded; R7 forward
    do_req(0, 1, 3, 0);
    do_req(0, 0, 5, 0);
    do_req(0, 1, 7, 0);            // R7 both owner and reader invalidated
    // R2 sharers, R9 evict clears bit
    do_req(0, 0, 1, 1); do_req(0, 0, 2, 1); do_req(0, 0, 9, 1);
    do_req(0, 2, 2, 1);
    do_req(0, 1, 9, 1);
    do_req(0, 0, 9, 1);            // R8 owner read, no forward
    do_req(0, 0, 4, 1);            // R7 forward to 9
    do_req(0, 2, 4, 1); do_req(0, 2, 9, 1); // R9 last bit gone -> unowned
    do_req(0, 1, 4, 1);            // R9 expect zero invalidations
    do_req(0, 1, 6, 2); do_req(0, 2, 6, 2); do_req(0, 1, 8, 2); // R9 owner evict
    do_req(0, 3, 8, 2);            // R2 op 3 leaves entry
    // R10 coarse groups
    do_req(1, 0, 5, 2); do_req(1, 0, 13, 2);
    do_req(1, 2, 5, 2);            // R10 evict keeps group bit
    do_req(1, 1, 6, 2);            // R10 expect 4,5,7,12..15
    do_req(1, 1, 63, 3); do_req(1, 0, 0, 3); do_req(1, 1, 62, 3);
    for (int b = 0; b < 4; b++) do_req(1, 0, b * 16 + 1, 0);
    do_req(1, 1, 33, 0);
    // random mix
    for (int i = 0; i < 500; i++) begin
      int m = i % 2;
      int o = $urandom_range(9);
      do_req(m, (o < 5) ? 0 : (o < 7) ? 1 : 2, $urandom_range(nn(m) - 1), $urandom_range(3));
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule